// File: doc/BRIEF.md
# Floating Condition Predicate Evaluator

This block decides whether a floating-point conditional predicate holds for the current condition flags. The flags are negative, zero, infinity and not-a-number. A consumer presents a predicate code together with a snapshot of the flags and pulses a valid strobe. One clock later the block returns the verdict, an illegal-code indication and an unordered-exception indication. Conditional branch, conditional set and conditional trap logic share the block.

The predicate code is split into fields. Bit 5 marks the code as illegal. Bit 4 selects a signalling test, which is not IEEE-aware and reports unordered operands. Bit 3 negates the test. The low bits pick one of eight base comparisons. The unordered indication only describes the current evaluation: nothing left from an earlier evaluation is carried into it.

Top module: `fpcc_eval`

## Requirements
- R1: While `rst_n` is low and after reset is released, `out_valid`, `cond_true`, `illegal` and `bsun_set` are all 0 until the first strobe.
- R2: A strobe on `in_valid` produces `out_valid` high exactly one cycle later, carrying that strobe's results. Without a strobe, `out_valid` is low and the other three outputs keep their values.
- R3: When predicate bit 5 is set, `illegal` is 1 and both `cond_true` and `bsun_set` are 0. When bit 5 is clear, `illegal` is 0.
- R4: With bits 5, 4 and 3 clear, the value of bits 2..0 selects the base test, written here in terms of the flags N, Z and NaN. 0 is never true. 1 is Z. 2 is N, Z and NaN all clear. 3 is Z, or both NaN and N clear. 4 is N set with Z and NaN clear. 5 is Z, or N set with NaN clear. 6 is Z and NaN both clear. 7 is NaN clear.
- R5: When bit 3 is set, the base test is 15 minus the value of bits 3..0, and `cond_true` is the inverse of that test. For example, code 0x0F is always true and code 0x0E is "not equal".
- R6: Bit 4 does not change `cond_true`. When bit 4 is set on a legal code and the NaN flag is set, `bsun_set` is 1.
- R7: When bit 4 is clear, or when the NaN flag is clear, `bsun_set` is 0.
- R8: The infinity flag has no effect on any output.
- R9: `bsun_set` reflects only the current evaluation. An evaluation that does not raise it returns 0, even right after one that did.
- R10: Predicate bits at position 6 and above, when `PRED_W` exceeds 6, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: evaluate this cycle's inputs |
| pred | input | PRED_W | Predicate code |
| cc_neg | input | 1 | Negative flag |
| cc_zero | input | 1 | Zero flag |
| cc_inf | input | 1 | Infinity flag |
| cc_nan | input | 1 | Not-a-number flag |
| out_valid | output | 1 | Results below belong to the previous cycle's strobe |
| cond_true | output | 1 | Predicate verdict |
| illegal | output | 1 | Predicate code is illegal |
| bsun_set | output | 1 | Signalling test met an unordered operand |

## Verification
The bench builds the block with `PRED_W` = 8. This puts two predicate bits above the decoded field within reach, so the bench can show they are ignored. It sweeps every 6-bit code against all sixteen flag combinations. It compares each verdict with a model written as ordered, equal, greater and less relations rather than a code table. Dedicated scenarios cover output hold between strobes, the infinity flag, and an unordered indication that does not carry over into the next evaluation.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int PRED_USED = 6;
  localparam int BASE_W    = 3;

  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } cc_t;

  typedef enum logic [BASE_W-1:0] {
    BT_NEVER = 3'd0,
    BT_EQ    = 3'd1,
    BT_GT    = 3'd2,
    BT_GE    = 3'd3,
    BT_LT    = 3'd4,
    BT_LE    = 3'd5,
    BT_GL    = 3'd6,
    BT_ORD   = 3'd7
  } base_e;

  typedef struct packed {
    logic  bad;
    logic  signalling;
    logic  invert;
    base_e base;
  } dec_t;

  // Split the 6-bit predicate field into its controls.
  function automatic dec_t split_pred(input logic [PRED_USED-1:0] p);
    dec_t d;
    d.bad        = p[5];
    d.signalling = p[4];
    d.invert     = p[3];
    d.base       = base_e'(p[3] ? ~p[2:0] : p[2:0]);
    return d;
  endfunction

  // Base comparison against the flags; the infinity flag plays no part.
  function automatic logic base_hit(input base_e b, input cc_t c);
    logic r;
    unique case (b)
      BT_NEVER: r = 1'b0;
      BT_EQ:    r = c.zero;
      BT_GT:    r = !(c.nan | c.zero | c.neg);
      BT_GE:    r = c.zero | !(c.nan | c.neg);
      BT_LT:    r = c.neg & !c.zero & !c.nan;
      BT_LE:    r = c.zero | (c.neg & !c.nan);
      BT_GL:    r = !(c.nan | c.zero);
      BT_ORD:   r = !c.nan;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] pred,
  output dec_t              dec
);

  assign dec = split_pred(pred[PRED_USED-1:0]);

  generate
    if (PRED_W > PRED_USED) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pred[PRED_W-1:PRED_USED];
    end
  endgenerate

endmodule

// File: rtl/fpcc_base.sv
module fpcc_base
  import fpcc_pkg::*;
(
  input  base_e base,
  input  cc_t   cc,
  output logic  hit
);

  logic unused_inf;
  assign unused_inf = cc.inf;

  assign hit = base_hit(base, cc);

endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PRED_W-1:0] pred,
  input  logic              cc_neg,
  input  logic              cc_zero,
  input  logic              cc_inf,
  input  logic              cc_nan,
  output logic              out_valid,
  output logic              cond_true,
  output logic              illegal,
  output logic              bsun_set
);

  cc_t  cc;
  dec_t dec;

  // Named internal events, used by the bound checker.
  logic dec_illegal;
  logic dec_signal;
  logic dec_invert;
  logic base_hit_w;
  logic next_true;
  logic next_bsun;

  assign cc = '{neg: cc_neg, zero: cc_zero, inf: cc_inf, nan: cc_nan};

  fpcc_decode #(.PRED_W(PRED_W)) u_decode (
    .pred (pred),
    .dec  (dec)
  );

  fpcc_base u_base (
    .base (dec.base),
    .cc   (cc),
    .hit  (base_hit_w)
  );

  assign dec_illegal = dec.bad;
  assign dec_signal  = dec.signalling;
  assign dec_invert  = dec.invert;
  assign next_true   = !dec_illegal & (base_hit_w ^ dec_invert);
  assign next_bsun   = !dec_illegal & dec_signal & cc.nan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cond_true <= 1'b0;
      illegal   <= 1'b0;
      bsun_set  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cond_true <= next_true;
        illegal   <= dec_illegal;
        bsun_set  <= next_bsun;
      end
    end
  end

endmodule

// File: rtl/fpcc_eval_chk.sv
module fpcc_eval_chk #(
  parameter int PRED_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PRED_W-1:0] pred,
  input logic              cc_nan,
  input logic              out_valid,
  input logic              cond_true,
  input logic              illegal,
  input logic              bsun_set,
  input logic              dec_illegal,
  input logic              dec_invert,
  input logic              base_hit_w
);

  p_strobe_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(cond_true) && $stable(illegal) && $stable(bsun_set)));

  p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!cond_true && !bsun_set));

  p_illegal_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (illegal == $past(pred[5])));

  p_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_illegal) |=> (cond_true == ($past(base_hit_w) ^ $past(dec_invert))));

  p_aware_no_bsun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pred[4]) |=> !bsun_set);

  p_ordered_no_bsun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cc_nan) |=> !bsun_set);

  p_signal_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred[4] && !pred[5] && cc_nan) |=> bsun_set);

endmodule

bind fpcc_eval fpcc_eval_chk #(.PRED_W(PRED_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .pred        (pred),
  .cc_nan      (cc_nan),
  .out_valid   (out_valid),
  .cond_true   (cond_true),
  .illegal     (illegal),
  .bsun_set    (bsun_set),
  .dec_illegal (dec_illegal),
  .dec_invert  (dec_invert),
  .base_hit_w  (base_hit_w)
);

// File: tb/test_fpcc_eval.sv
module test_fpcc_eval;

  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [PW-1:0] pred = '0;
  logic          cc_neg = 1'b0, cc_zero = 1'b0, cc_inf = 1'b0, cc_nan = 1'b0;
  logic          out_valid, cond_true, illegal, bsun_set;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  fpcc_eval #(.PRED_W(PW)) i_fpcc_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred(pred),
    .cc_neg(cc_neg), .cc_zero(cc_zero), .cc_inf(cc_inf), .cc_nan(cc_nan),
    .out_valid(out_valid), .cond_true(cond_true), .illegal(illegal), .bsun_set(bsun_set)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Independent model: relations first, then predicate selection.
  function automatic logic model_true(input logic [5:0] p, input logic n, input logic z, input logic q);
    logic ord, eq, gt, lt, r;
    int   low;
    int   b;
    ord = !q; eq = z; gt = ord && !z && !n; lt = ord && !z && n;
    low = int'(p[3:0]);
    b = (low >= 8) ? 15 - low : low;
    case (b)
      0: r = 0;
      1: r = eq;
      2: r = gt;
      3: r = gt || eq;
      4: r = lt;
      5: r = lt || eq;
      6: r = gt || lt;
      default: r = ord;
    endcase
    if (low >= 8) r = !r;
    if (p[5]) r = 0;
    return r;
  endfunction

  // Drive one strobe at a falling edge, sample at the next falling edge.
  task automatic evaluate(input logic [PW-1:0] p, input logic n, input logic z, input logic i, input logic q);
    @(negedge clk);
    pred = p; cc_neg = n; cc_zero = z; cc_inf = i; cc_nan = q; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", out_valid, 1'b0);
    check("R1", "cond_true in reset", cond_true, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", out_valid, 1'b0);
    check("R1", "cond_true after reset", cond_true, 1'b0);
    check("R1", "illegal after reset", illegal, 1'b0);
    check("R1", "bsun_set after reset", bsun_set, 1'b0);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 64; p++) begin
      for (int f = 0; f < 16; f++) begin
        logic n, z, i, q, bad, exp_b;
        string tag;
        n = f[3]; z = f[2]; i = f[1]; q = f[0];
        bad = p[5];
        exp_b = !bad && p[4] && q;
        tag = bad ? "R3" : (p[3] ? "R5" : (p[4] ? "R6" : "R4"));
        evaluate(PW'(p), n, z, i, q);
        check("R2", "out_valid", out_valid, 1'b1);
        check(tag, $sformatf("cond_true p=%02h f=%0h", p, f), cond_true,
              model_true(6'(p), n, z, q));
        check("R3", $sformatf("illegal p=%02h", p), illegal, bad);
        check(exp_b ? "R6" : "R7", $sformatf("bsun_set p=%02h f=%0h", p, f), bsun_set, exp_b);
      end
    end
  endtask

  task automatic t_hold;
    evaluate(8'h1F, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6", "bsun before hold", bsun_set, 1'b1);
    @(negedge clk);
    cc_nan = 1'b0; pred = 8'h20;
    @(negedge clk);
    check("R2", "out_valid idle", out_valid, 1'b0);
    check("R2", "cond_true held", cond_true, 1'b1);
    check("R2", "bsun_set held", bsun_set, 1'b1);
    check("R2", "illegal held", illegal, 1'b0);
  endtask

  task automatic t_not_sticky;
    evaluate(8'h12, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9", "bsun raised", bsun_set, 1'b1);
    evaluate(8'h12, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", "bsun not carried", bsun_set, 1'b0);
    check("R9", "gt after ordered", cond_true, 1'b1);
  endtask

  task automatic t_inf;
    for (int p = 0; p < 32; p++) begin
      logic t0, b0;
      evaluate(PW'(p), 1'b1, 1'b0, 1'b0, 1'b0);
      t0 = cond_true; b0 = bsun_set;
      evaluate(PW'(p), 1'b1, 1'b0, 1'b1, 1'b0);
      check("R8", $sformatf("inf cond p=%02h", p), cond_true, t0);
      check("R8", $sformatf("inf bsun p=%02h", p), bsun_set, b0);
    end
  endtask

  task automatic t_upper_bits;
    evaluate(8'hC4, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", "upper bits cond (LT)", cond_true, 1'b1);
    check("R10", "upper bits legal", illegal, 1'b0);
    evaluate(8'h41, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "upper bits cond (EQ)", cond_true, 1'b0);
    evaluate(8'h9F, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10", "upper bits bsun", bsun_set, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_not_sticky();
    t_inf();
    t_upper_bits();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule